// File: doc/BRIEF.md
# Chain Printer Hammer Scheduler

This block sequences the hammers of a 132-column chain printer. Type slugs travel past the hammers on a moving chain. In any one time slot only one slug sits squarely in front of one hammer. In each slot the block therefore picks that single column, looks up the character the line wants there, works out which symbol is under the hammer, and strikes only when the two agree. It never fires two hammers at once.

One clock cycle is one time slot. A scan is 150 slots long. The first 132 slots give every column one chance. The remaining 18 slots are synchronisation time, and no hammer may strike during them. The hammer slots of a scan fall into three subscans. The chain moves one character pitch per scan, so after 48 scans every column has faced every symbol of the 48-symbol set, and the line is finished.

A host places a line of 6-bit character codes on the line input and pulses start. The block captures the line and then reports each strike as a one-cycle strobe with a column number. When the line is finished it raises a one-cycle completion pulse.

Top module: `hammer_sched`

## Requirements
- R1: After reset the fire strobe and the line-done flag are low. While no start has been accepted, no hammer fires.
- R2: Within a scan, hammer slot i (0..131) serves column 3*(i mod 44) + i/44. Subscan k is therefore slots 44k..44k+43, and it visits the columns c with c mod 3 = k in increasing order.
- R3: In scan s, the slug in front of column c (subscan k = c mod 3) carries symbol ((s + c + 44k) mod 240) mod 48. A column fires when this symbol equals its wanted code. The strobe, with the column on the column output, goes high 2 + 150*s + i clock edges after the edge that accepted start, where i is the column's slot from R2.
- R4: No strike occurs in the cycle that follows a synchronisation slot (slots 132..149 of each scan).
- R5: Every column whose code is 0..47 fires exactly once per line, and a column already struck in the current line never fires again.
- R6: A column whose code is in the range 48..63 (blank; 63 is the usual blank code) never fires.
- R7: The line-done flag is high for exactly one cycle, 48*150 + 1 clock edges after the edge that accepted start.
- R8: A start while a line is in progress is ignored. The line captured at the accepted start stays in use, and the slot timing does not change.
- R9: A start given in the cycle in which the line-done flag is high is accepted and begins a new line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, one slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line; the line input is captured on the accepting edge |
| lineBuf | input | 792 | 132 codes of 6 bits; column c is bits 6c+5..6c |
| fire | output | 1 | One-cycle hammer strike strobe |
| fireCol | output | 8 | Column struck, valid while fire is high |
| lineDone | output | 1 | One-cycle pulse when the line has finished |

## Verification
Every result is counted in clock edges from the edge that accepts start. The slot counters load on that edge, so slot i of scan s is present after edge 1 + 150s + i. The strike register adds one more edge, so a strike is due after edge 2 + 150s + i. The completion pulse is due after edge 7201. For each column, the bench derives the scan and slot in which its strike must appear using the R2 and R3 formulas. It samples on the falling edge and tags every strike with its edge number. A strike that comes one cycle early or late, that names the wrong column, or that falls after a sync slot is reported. A strike that repeats, or one that is due but never arrives, is reported too.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int NCOLS      = 132;
  localparam int NSYM       = 48;
  localparam int NSLUG      = 240;
  localparam int NSUB       = 3;
  localparam int SUB_OFFSET = 44;
  localparam int SCAN_SLOTS = 150;
  localparam int NSCANS     = 48;
  localparam int CODEW      = 6;

  localparam int PER_SUB = NCOLS / NSUB;
  localparam int COLW    = $clog2(NCOLS);
  localparam int SLOTW   = $clog2(SCAN_SLOTS);
  localparam int SCANW   = $clog2(NSCANS);
  localparam int SUBW    = $clog2(NSUB + 1);
  localparam int POSW    = $clog2(PER_SUB);
  localparam int BUFW    = NCOLS * CODEW;

  typedef struct packed {
    logic             load;
    logic             slotValid;
    logic [COLW-1:0]  col;
    logic [SCANW-1:0] scan;
    logic [SUBW-1:0]  sub;
  } strobe_t;
endpackage

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strb,
  output logic    lineDone
);
  logic             busy;
  logic [SLOTW-1:0] slot;
  logic [SCANW-1:0] scan;
  logic [POSW-1:0]  pos;
  logic [SUBW-1:0]  sub;
  logic             lastSlot;
  logic             hammerSlot;

  assign lastSlot   = (int'(slot) == SCAN_SLOTS - 1);
  assign hammerSlot = (int'(slot) < NCOLS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      slot     <= '0;
      scan     <= '0;
      pos      <= '0;
      sub      <= '0;
      lineDone <= 1'b0;
    end else begin
      lineDone <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          slot <= '0;
          scan <= '0;
          pos  <= '0;
          sub  <= '0;
        end
      end else if (lastSlot) begin
        slot <= '0;
        pos  <= '0;
        sub  <= '0;
        if (int'(scan) == NSCANS - 1) begin
          busy     <= 1'b0;
          lineDone <= 1'b1;
        end else begin
          scan <= scan + 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
        if (hammerSlot) begin
          if (int'(pos) == PER_SUB - 1) begin
            pos <= '0;
            sub <= sub + 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strb.load      = start && !busy;
    strb.slotValid = busy && hammerSlot;
    strb.col       = COLW'(int'(pos) * NSUB + int'(sub));
    strb.scan      = scan;
    strb.sub       = sub;
  end

  // R7: the completion pulse lasts a single cycle and the sequencer is idle during it
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> !busy);

  // R8: a start during a line leaves the slot count running
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastSlot) |=> (busy && slot == $past(slot) + 1'b1));
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [BUFW-1:0] lineBuf,
  output logic            fire,
  output logic [COLW-1:0] fireCol
);
  logic [CODEW-1:0] lineReg [NCOLS];
  logic [NCOLS-1:0] struck;
  logic [CODEW-1:0] slugSym;
  logic [CODEW-1:0] wanted;
  logic             match;

  always_comb begin
    int sum;
    sum     = int'(strb.scan) + int'(strb.col) + SUB_OFFSET * int'(strb.sub);
    slugSym = CODEW'((sum % NSLUG) % NSYM);
    wanted  = lineReg[strb.col];
    match   = strb.slotValid && (int'(wanted) < NSYM) &&
              (wanted == slugSym) && !struck[strb.col];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fire    <= 1'b0;
      fireCol <= '0;
      struck  <= '0;
    end else begin
      fire <= match;
      if (match) fireCol <= strb.col;
      if (strb.load) struck <= '0;
      else if (match) struck[strb.col] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      for (int j = 0; j < NCOLS; j++) lineReg[j] <= lineBuf[j*CODEW +: CODEW];
    end
  end

  // R4: nothing strikes after a sync slot or while idle
  a_r4_sync_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strb.slotValid |=> !fire);

  // R5: a column already struck in this line stays quiet
  a_r5_no_refire: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slotValid && struck[strb.col]) |=> !fire);

  // R3: the reported column always names a real hammer
  a_r3_col_range: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (int'(fireCol) < NCOLS));
endmodule

// File: rtl/hammer_sched.sv
module hammer_sched
  import hs_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [BUFW-1:0] lineBuf,
  output logic            fire,
  output logic [COLW-1:0] fireCol,
  output logic            lineDone
);
  strobe_t strb;

  hs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .strb     (strb),
    .lineDone (lineDone)
  );

  hs_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .lineBuf (lineBuf),
    .fire    (fire),
    .fireCol (fireCol)
  );
endmodule

// File: tb/sim_hammer_sched.sv
`timescale 1ns/1ps
module sim_hammer_sched;
  localparam int COLS = 132;
  localparam int SYMS = 48;
  localparam int SLOTS = 150;
  localparam int SCANS = 48;
  localparam int DONE_EDGE = SCANS * SLOTS + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [COLS*6-1:0] lineBuf = '0;
  logic fire;
  logic [7:0] fireCol;
  logic lineDone;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  hammer_sched u0 (
    .clk(clk), .rstN(rstN), .start(start), .lineBuf(lineBuf),
    .fire(fire), .fireCol(fireCol), .lineDone(lineDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dueEdge(input int c, input int code);
    int k, i, s;
    if (code >= SYMS) return -1;
    k = c % 3;
    i = 44 * k + c / 3;
    s = ((code - (c + 44 * k) % SYMS) % SYMS + SYMS) % SYMS;
    return 2 + SLOTS * s + i;
  endfunction

  // runs one line; preIssued: start already raised; chain: raise start at done and return
  task automatic runLine(input logic [COLS*6-1:0] buf_, input string name,
                         input bit preIssued, input bit chain,
                         input bit midStart, input logic [COLS*6-1:0] altBuf);
    int due [COLS];
    bit seen [COLS];
    int expFires = 0, gotFires = 0, missing = 0;
    for (int c = 0; c < COLS; c++) begin
      due[c] = dueEdge(c, int'(buf_[c*6 +: 6]));
      seen[c] = 1'b0;
      if (due[c] >= 0) expFires++;
    end
    if (!preIssued) begin
      @(negedge clk);
      lineBuf = buf_;
      start = 1'b1;
    end
    for (int m = 1; m <= DONE_EDGE + 3; m++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (midStart && m == 3000) begin
        lineBuf = altBuf;   // R8: must be ignored
        start = 1'b1;
      end
      if (fire) begin
        int fc = int'(fireCol);
        gotFires++;
        // R4: no strike after a sync slot
        check(((m - 2) % SLOTS) < 132, "R4", {name, " strike after sync slot"}, (m - 2) % SLOTS, 131);
        if (fc < COLS) begin
          // R3/R2: timing and column; R5: no repeat
          check(due[fc] == m, "R3", {name, " strike edge for column"}, m, due[fc]);
          check(!seen[fc], "R5", {name, " repeated strike column"}, fc, -1);
          seen[fc] = 1'b1;
        end else begin
          check(1'b0, "R3", {name, " column out of range"}, fc, COLS - 1);
        end
      end
      if (m >= DONE_EDGE - 1 && m <= DONE_EDGE + 1)
        check(lineDone == (m == DONE_EDGE), "R7", {name, " line-done pulse"}, int'(lineDone), int'(m == DONE_EDGE));
      else if (lineDone)
        check(1'b0, "R7", {name, " stray line-done"}, m, DONE_EDGE);
      if (chain && m == DONE_EDGE) begin
        start = 1'b1;   // R9: start together with done
        break;
      end
    end
    for (int c = 0; c < COLS; c++) if (due[c] >= 0 && !seen[c]) missing++;
    check(missing == 0, "R5", {name, " columns never struck"}, missing, 0);
    check(gotFires == expFires, "R6", {name, " strike count (blank columns silent)"}, gotFires, expFires);
  endtask

  function automatic logic [COLS*6-1:0] mkBuf(input int kind);
    logic [COLS*6-1:0] b;
    for (int c = 0; c < COLS; c++) begin
      case (kind)
        0: b[c*6 +: 6] = 6'(c % SYMS);
        1: b[c*6 +: 6] = 6'd63;
        2: b[c*6 +: 6] = 6'((c * 7) % 64);
        3: b[c*6 +: 6] = 6'd5;
        default: b[c*6 +: 6] = 6'd0;
      endcase
    end
    return b;
  endfunction

  task automatic testReset();
    for (int n = 0; n < 3; n++) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(!fire, "R1", "fire after reset", int'(fire), 0);
    check(!lineDone, "R1", "line-done after reset", int'(lineDone), 0);
    lineBuf = mkBuf(0);
    begin
      int strikes = 0;
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        if (fire || lineDone) strikes++;
      end
      check(strikes == 0, "R1", "activity without start", strikes, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    testReset();
    runLine(mkBuf(0), "allSymbols", 1'b0, 1'b0, 1'b0, '0);
    runLine(mkBuf(1), "allBlank", 1'b0, 1'b0, 1'b0, '0);
    runLine(mkBuf(2), "mixedBlank", 1'b0, 1'b0, 1'b1, mkBuf(4));
    runLine(mkBuf(3), "sameCode", 1'b0, 1'b1, 1'b0, '0);
    lineBuf = mkBuf(0);
    runLine(mkBuf(0), "backToBack", 1'b1, 1'b0, 1'b0, '0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule